// File: doc/BRIEF.md
# Two-Channel Odometer Pulse Counter with Switchable Direction

This block counts wheel pulses on two channels. Each channel has its own 16-bit up/down counter, and the counter moves by one for each rising edge seen on that channel's pulse line. A drive-state line selects the counting direction for both channels. That line is honoured only after the host has turned on the direction control with a one-bit command write. While the control is off, every pulse counts upward.

The pulse lines and the drive-state line come from outside the clock domain, so each passes through a two-flop synchroniser before edge detection. A periodic snapshot strobe from the sampling timer copies both counters and the synchronised drive-state bit into output latches. The host reads those latches between strobes. The live counters are never exposed directly.

Top module: `odo_pulse_counter`

## Requirements
- R1: After reset, both channel counters are zero, and the first snapshot returns 0 for both channels and 0 for the drive-state bit.
- R2: A counter steps once for each 0-to-1 transition of its synchronised pulse line. A pulse line held high, or held low, causes no further steps.
- R3: The direction-control enable is 0 after reset. It changes only on a host write (`en_wr` high), which loads `en_wdata`, and its value is visible on `dir_en`.
- R4: While the enable is 1 and the synchronised drive-state is 1, each counted pulse adds one.
- R5: While the enable is 1 and the synchronised drive-state is 0, each counted pulse subtracts one.
- R6: While the enable is 0, each counted pulse adds one, whatever the drive-state level.
- R7: Counters wrap modulo 2^16. Stepping down from 0 gives 16'hFFFF, and stepping up from 16'hFFFF gives 0.
- R8: On a clock edge with `snap_stb` high, `snap_cnt` takes both counter values as they stood before that edge and `snap_state` takes the synchronised drive-state bit. Without a strobe, the latches hold their values. Channel c occupies bits [16c+15:16c] of `snap_cnt`.
- R9: A pulse rise that is first sampled at clock edge k updates the counter at edge k+2. A strobe at edge k+2 therefore still captures the old value, and a strobe at edge k+3 captures the new one. Drive-state has the same two-edge synchroniser delay.
- R10: An enable write at edge w applies to counter updates from edge w+1 onward. An update at edge w itself uses the previous enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 2 | Odometer pulse line per channel, asynchronous |
| drive_state | input | 1 | Drive-state level, asynchronous; 1 = forward |
| en_wr | input | 1 | Host write strobe for the direction-control enable |
| en_wdata | input | 1 | Enable value loaded on a write |
| snap_stb | input | 1 | Sampling strobe that loads the output latches |
| dir_en | output | 1 | Current direction-control enable |
| snap_cnt | output | 32 | Latched counters, channel 0 in the low half |
| snap_state | output | 1 | Latched synchronised drive-state bit |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit counters and two synchroniser stages. With these values, reaching the wrap points takes only a single pulse from zero, so both the down-wrap to 16'hFFFF and the up-wrap back to zero are exercised directly. The short synchroniser also lets a strobe held high across consecutive edges expose the exact two-edge pulse latency. A random phase then mixes enable writes, drive-state changes, pulses and strobes on neighbouring edges, which covers a write landing in the same cycle as a counted pulse.

// File: rtl/odo_pkg.sv
package odo_pkg;

  // Next counter value for one counted pulse; wraps naturally at the width.
  function automatic logic [15:0] odo_step16(input logic [15:0] cur, input logic up);
    return up ? cur + 16'd1 : cur - 16'd1;
  endfunction

  // Direction rule: the drive-state only matters while the control is enabled.
  function automatic logic odo_count_up(input logic enable, input logic ds);
    return (!enable) || ds;
  endfunction

endpackage

// File: rtl/odo_sync.sv
module odo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/odo_dir_ctrl.sv
module odo_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic ds_sync,
  output logic dir_en,
  output logic count_up
);
  import odo_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dir_en <= 1'b0;
    else if (en_wr) dir_en <= en_wdata;
  end

  // Uses the registered enable, so a write reaches updates one edge later.
  assign count_up = odo_count_up(dir_en, ds_sync);
endmodule

// File: rtl/odo_channel.sv
module odo_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_s,
  input  logic             count_up,
  output logic [CNT_W-1:0] cnt,
  output logic             step_up,
  output logic             step_dn
);
  logic pulse_d;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_d <= 1'b0;
    else        pulse_d <= pulse_s;
  end

  assign rise    = pulse_s & ~pulse_d;
  assign step_up = rise & count_up;
  assign step_dn = rise & ~count_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (step_up) cnt <= cnt + CNT_W'(1);
    else if (step_dn) cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/odo_pulse_counter.sv
module odo_pulse_counter #(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       pulse_in,
  input  logic                    drive_state,
  input  logic                    en_wr,
  input  logic                    en_wdata,
  input  logic                    snap_stb,
  output logic                    dir_en,
  output logic [NUM_CH*CNT_W-1:0] snap_cnt,
  output logic                    snap_state
);
  localparam int SW = NUM_CH + 1;

  logic [SW-1:0]           sync_q;
  logic [NUM_CH-1:0]       pulse_s;
  logic                    ds_s;
  logic                    count_up;
  logic [NUM_CH-1:0]       step_up;
  logic [NUM_CH-1:0]       step_dn;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;

  odo_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({drive_state, pulse_in}), .q(sync_q)
  );
  assign pulse_s = sync_q[NUM_CH-1:0];
  assign ds_s    = sync_q[NUM_CH];

  odo_dir_ctrl u_dir (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .ds_sync(ds_s), .dir_en(dir_en), .count_up(count_up)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    odo_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pulse_s(pulse_s[c]), .count_up(count_up),
      .cnt(cnt_flat[c*CNT_W +: CNT_W]), .step_up(step_up[c]), .step_dn(step_dn[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cnt   <= '0;
      snap_state <= 1'b0;
    end else if (snap_stb) begin
      snap_cnt   <= cnt_flat;
      snap_state <= ds_s;
    end
  end
endmodule

// File: rtl/odo_pulse_counter_chk.sv
module odo_pulse_counter_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input logic [NUM_CH-1:0]       step_up,
  input logic [NUM_CH-1:0]       step_dn,
  input logic                    dir_en,
  input logic                    en_wr,
  input logic                    snap_stb,
  input logic [NUM_CH*CNT_W-1:0] snap_cnt
);
  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_wr) |-> $stable(dir_en)); // R3

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_stb |=> $stable(snap_cnt)); // R8

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_stb |=> (snap_cnt == $past(cnt_flat))); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step_up[c], step_dn[c]})); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_up[c] && !step_dn[c]) |=> $stable(cnt_flat[c*CNT_W +: CNT_W])); // R2

    AST_DISABLED_UP: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_en |-> !step_dn[c]); // R6

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step_up[c] |=> (cnt_flat[c*CNT_W +: CNT_W] ==
                      CNT_W'($past(cnt_flat[c*CNT_W +: CNT_W]) + 1))); // R7

    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step_dn[c] |=> (cnt_flat[c*CNT_W +: CNT_W] ==
                      CNT_W'($past(cnt_flat[c*CNT_W +: CNT_W]) - 1))); // R7
  end
endmodule

bind odo_pulse_counter odo_pulse_counter_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat), .step_up(step_up), .step_dn(step_dn),
  .dir_en(dir_en), .en_wr(en_wr), .snap_stb(snap_stb), .snap_cnt(snap_cnt)
);

// File: tb/odo_pulse_counter_bench.sv
module odo_pulse_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pulse_in = '0;
  logic        drive_state = 1'b0;
  logic        en_wr = 1'b0;
  logic        en_wdata = 1'b0;
  logic        snap_stb = 1'b0;
  logic        dir_en;
  logic [31:0] snap_cnt;
  logic        snap_state;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  odo_pulse_counter u_odo_pulse_counter (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .drive_state(drive_state),
    .en_wr(en_wr), .en_wdata(en_wdata), .snap_stb(snap_stb),
    .dir_en(dir_en), .snap_cnt(snap_cnt), .snap_state(snap_state)
  );

  // Behavioural model: input history per edge, integer counters.
  int m_cnt[2];
  int m_snap[2];
  bit m_st, m_en;
  bit ph1[2], ph2[2], ph3[2];
  bit dh1, dh2;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_snap[c] = 0; ph1[c] = 0; ph2[c] = 0; ph3[c] = 0;
      end
      m_st = 0; m_en = 0; dh1 = 0; dh2 = 0;
    end else begin
      if (snap_stb) begin
        m_snap[0] = m_cnt[0]; m_snap[1] = m_cnt[1]; m_st = dh2;
      end
      for (int c = 0; c < 2; c++) begin
        if (ph2[c] && !ph3[c]) begin
          if (!m_en || dh2) m_cnt[c] = (m_cnt[c] + 1) % 65536;
          else              m_cnt[c] = (m_cnt[c] + 65535) % 65536;
        end
        ph3[c] = ph2[c]; ph2[c] = ph1[c]; ph1[c] = pulse_in[c];
      end
      dh2 = dh1; dh1 = drive_state;
      if (en_wr) m_en = en_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " snap ch0"}, int'(snap_cnt[15:0]), m_snap[0]);
      chk({cur_req, " snap ch1"}, int'(snap_cnt[31:16]), m_snap[1]);
      chk({cur_req, " snap state"}, int'(snap_state), int'(m_st));
      chk({cur_req, " dir_en"}, int'(dir_en), int'(m_en));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(logic [1:0] mask, int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = mask; cyc(2);
      pulse_in = 2'b00; cyc(2);
    end
  endtask

  task automatic snap();
    cyc(4);
    snap_stb = 1'b1; cyc(1);
    snap_stb = 1'b0; cyc(1);
  endtask

  task automatic write_en(logic v);
    en_wr = 1'b1; en_wdata = v; cyc(1);
    en_wr = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    cur_req = "R1";
    snap();
    chk("R1 ch0 zero", int'(snap_cnt[15:0]), 0);
    chk("R1 ch1 zero", int'(snap_cnt[31:16]), 0);
    chk("R3 enable off after reset", int'(dir_en), 0);

    cur_req = "R6";
    pulses(2'b11, 3); pulses(2'b10, 2); snap();
    chk("R6 disabled up ch0", int'(snap_cnt[15:0]), 3);
    chk("R6 disabled up ch1", int'(snap_cnt[31:16]), 5);

    cur_req = "R2";
    pulse_in = 2'b01; cyc(20); pulse_in = 2'b00; snap();
    chk("R2 held high counts once", int'(snap_cnt[15:0]), 4);

    cur_req = "R4";
    write_en(1'b1);
    chk("R3 enable readback", int'(dir_en), 1);
    drive_state = 1'b1; cyc(4);
    pulses(2'b01, 2); snap();
    chk("R4 enabled forward", int'(snap_cnt[15:0]), 6);
    chk("R8 state bit latched", int'(snap_state), 1);

    cur_req = "R5";
    drive_state = 1'b0; cyc(4);
    pulses(2'b11, 4); snap();
    chk("R5 enabled reverse ch0", int'(snap_cnt[15:0]), 2);
    chk("R5 enabled reverse ch1", int'(snap_cnt[31:16]), 1);

    cur_req = "R7";
    pulses(2'b10, 2); snap();
    chk("R7 down wrap", int'(snap_cnt[31:16]), 16'hFFFF);
    write_en(1'b0);
    pulses(2'b10, 1); snap();
    chk("R7 up wrap", int'(snap_cnt[31:16]), 0);

    cur_req = "R8";
    pulses(2'b01, 1); cyc(6);
    chk("R8 latch holds without strobe", int'(snap_cnt[15:0]), 2);
    snap();
    chk("R8 latch updates on strobe", int'(snap_cnt[15:0]), 3);

    cur_req = "R9";
    snap_stb = 1'b1;
    pulse_in = 2'b01; cyc(6); pulse_in = 2'b00; cyc(4);
    snap_stb = 1'b0; cyc(2);

    cur_req = "R10";
    write_en(1'b1);
    for (int i = 0; i < 200; i++) begin
      pulse_in = 2'($urandom_range(0, 3));
      drive_state = 1'($urandom_range(0, 1));
      en_wr = (i % 7 == 3);
      en_wdata = 1'($urandom_range(0, 1));
      snap_stb = 1'($urandom_range(0, 1));
      cyc(1);
    end

    cur_req = "R4";
    for (int i = 0; i < 2000; i++) begin
      if (i % 3 == 0) pulse_in = 2'($urandom_range(0, 3));
      if (i % 40 == 0) drive_state = ~drive_state;
      en_wr = (i % 97 == 0);
      en_wdata = 1'($urandom_range(0, 1));
      snap_stb = (i % 5 == 0);
      cyc(1);
    end
    en_wr = 1'b0; snap_stb = 1'b0; pulse_in = 2'b00;
    cyc(8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule